// File: doc/BRIEF.md
# Multi-Channel DMA Descriptor Register Block

This block holds the programming state of several DMA channels inside a bus bridge and runs a small word counter for each one. Every channel owns three 32-bit registers in a shared register window: a local-side address, a host-side address and a combined length/control word. Software programs the two addresses, then writes the control word with its start bit set. From then on the channel asks a data mover for beats. Each beat the mover accepts moves both addresses on by one word and takes one off the remaining count. When the count runs out, the channel drops its request and gives a single-cycle completion pulse.

The control word holds the remaining word count, a start/busy bit, a direction bit and four preserved control bits. The chain, priority and byte-swap bits are only stored, so that a software read-modify-write returns them unchanged. Each channel group starts 0x10 bytes after the previous one. Register reads are combinational. Register writes and beats take effect on the next rising clock edge.

Top module: `dma_chan_regs`

## Requirements
- R1: Channel c occupies byte offsets 0x10*c to 0x10*c+0xF. Offset +0x0 is the local address, +0x4 is the host address and +0x8 is the control word. Offset +0xC reads 0. Any group at or beyond NUM_CH reads 0 and ignores writes.
- R2: In the control word, bits 21:0 hold the remaining count in 32-bit words, which is the byte length divided by 4. Bit 28 is the direction: 0 moves data toward the host buffer, 1 moves it away. Bits 27, 25, 23 and 22 are preserved control bits that read back exactly as written. Bits 31:29 and bit 26 always read 0.
- R3: An idle channel that receives a control write with bit 24 set and a nonzero count becomes busy on the next cycle. While busy, bit 24 of the control word reads 1 and the channel's beat_req output is 1.
- R4: While a channel is busy, every write to any of its three registers is ignored, including a second start.
- R5: A beat is accepted when beat_req and beat_ack are both 1 for that channel. One cycle later, both address registers have increased by 4 and the count has decreased by 1. A beat_ack to an idle channel changes nothing.
- R6: When the beat that takes the count from 1 to 0 is accepted, busy clears on the next cycle. At the same time xfer_done pulses high for exactly one cycle.
- R7: A start write with a count of 0 never raises busy. It pulses xfer_done for one cycle on the next cycle.
- R8: Channels are independent. A beat, start or write aimed at one channel leaves the registers of every other channel unchanged.
- R9: Reset clears every register, busy flag and done pulse to 0.
- R10: The mv_dir, mv_local_addr and mv_host_addr outputs carry each channel's current direction bit and live address registers. Channel c uses slice [32*c +: 32] of each address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+4 | Byte offset into the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| beat_req | output | NUM_CH | Per-channel beat request, high while busy |
| beat_ack | input | NUM_CH | Per-channel beat acceptance from the data mover |
| mv_dir | output | NUM_CH | Per-channel direction bit |
| mv_local_addr | output | 32*NUM_CH | Current local addresses, packed by channel |
| mv_host_addr | output | 32*NUM_CH | Current host addresses, packed by channel |
| xfer_done | output | NUM_CH | One-cycle completion pulse per channel |

## Verification
The bench builds the block with NUM_CH set to 3. This gives a two-bit channel field in which the fourth group (offset 0x30) is unpopulated, so decode of an absent channel can be checked for both reads and writes. Three channels also allow one channel to finish, one to complete with a zero count and one to run while beats are offered to an idle neighbour, all in the same run. Together these cover independence between channels and the rule that acknowledges to an idle channel are ignored.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int REG_W      = 32;
    localparam int WORD_BYTES = 4;
    localparam int CNT_W      = 22;
    localparam int GRP_SHIFT  = 4;   // 0x10 stride per channel
    localparam int START_BIT  = 24;
    localparam int DIR_BIT    = 28;
    localparam int KEEP_W     = 4;

    typedef logic [REG_W-1:0] word_t;

    localparam logic [1:0] SEL_LOCAL = 2'd0;
    localparam logic [1:0] SEL_HOST  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    typedef struct packed {
        word_t              local_addr;
        word_t              host_addr;
        logic [CNT_W-1:0]   cnt;
        logic               dir;
        logic [KEEP_W-1:0]  keep;   // {b27, b25, b23, b22}
        logic               busy;
        logic               done;
    } chan_t;

    function automatic word_t ctrl_image(chan_t s);
        word_t w;
        w = '0;
        w[CNT_W-1:0] = s.cnt;
        w[22]        = s.keep[0];
        w[23]        = s.keep[1];
        w[START_BIT] = s.busy;
        w[25]        = s.keep[2];
        w[27]        = s.keep[3];
        w[DIR_BIT]   = s.dir;
        return w;
    endfunction
endpackage

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
    import dma_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  word_t       wr_data,
    input  logic        beat_ack,
    output chan_t       state
);
    chan_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^{wr_data[31:29], wr_data[26]};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (wr_en && !st_q.busy) begin
            case (wr_sel)
                SEL_LOCAL: st_d.local_addr = wr_data;
                SEL_HOST:  st_d.host_addr  = wr_data;
                SEL_CTRL: begin
                    st_d.cnt  = wr_data[CNT_W-1:0];
                    st_d.dir  = wr_data[DIR_BIT];
                    st_d.keep = {wr_data[27], wr_data[25], wr_data[23], wr_data[22]};
                    if (wr_data[START_BIT]) begin
                        if (wr_data[CNT_W-1:0] != '0) st_d.busy = 1'b1;
                        else                          st_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (st_q.busy && beat_ack) begin
            st_d.local_addr = st_q.local_addr + REG_W'(WORD_BYTES);
            st_d.host_addr  = st_q.host_addr + REG_W'(WORD_BYTES);
            st_d.cnt        = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [CH_W-1:0] ch_sel,
    input  logic [1:0]      word_sel,
    input  word_t           local_v [NUM_CH],
    input  word_t           host_v  [NUM_CH],
    input  word_t           ctrl_v  [NUM_CH],
    output word_t           rdata
);
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CH_W'(c)) begin
                case (word_sel)
                    SEL_LOCAL: rdata = local_v[c];
                    SEL_HOST:  rdata = host_v[c];
                    SEL_CTRL:  rdata = ctrl_v[c];
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW     = CH_W + GRP_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [AW-1:0]           reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic [NUM_CH-1:0]       beat_req,
    input  logic [NUM_CH-1:0]       beat_ack,
    output logic [NUM_CH-1:0]       mv_dir,
    output logic [NUM_CH*REG_W-1:0] mv_local_addr,
    output logic [NUM_CH*REG_W-1:0] mv_host_addr,
    output logic [NUM_CH-1:0]       xfer_done
);
    logic [CH_W-1:0] ch_sel;
    logic [1:0]      word_sel;
    logic            unused_lsb;

    assign ch_sel     = reg_addr[AW-1:GRP_SHIFT];
    assign word_sel   = reg_addr[3:2];
    assign unused_lsb = ^reg_addr[1:0];

    chan_t st      [NUM_CH];
    word_t local_v [NUM_CH];
    word_t host_v  [NUM_CH];
    word_t ctrl_v  [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_wr;
        assign sel_wr = reg_we && (ch_sel == CH_W'(c));

        dma_chan_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel_wr),
            .wr_sel   (word_sel),
            .wr_data  (reg_wdata),
            .beat_ack (beat_ack[c]),
            .state    (st[c])
        );

        assign local_v[c] = st[c].local_addr;
        assign host_v[c]  = st[c].host_addr;
        assign ctrl_v[c]  = ctrl_image(st[c]);

        assign beat_req[c]                     = st[c].busy;
        assign xfer_done[c]                    = st[c].done;
        assign mv_dir[c]                       = st[c].dir;
        assign mv_local_addr[c*REG_W +: REG_W] = st[c].local_addr;
        assign mv_host_addr[c*REG_W +: REG_W]  = st[c].host_addr;
    end

    dma_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
        .ch_sel   (ch_sel),
        .word_sel (word_sel),
        .local_v  (local_v),
        .host_v   (host_v),
        .ctrl_v   (ctrl_v),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH-1:0]    beat_req,
    input logic [NUM_CH-1:0]    beat_ack,
    input logic [NUM_CH-1:0]    xfer_done,
    input logic [NUM_CH*32-1:0] mv_local_addr,
    input logic [NUM_CH*32-1:0] mv_host_addr
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_req[c] && beat_ack[c]) |=>
                (mv_local_addr[c*32 +: 32] == $past(mv_local_addr[c*32 +: 32]) + 32'd4) &&
                (mv_host_addr[c*32 +: 32]  == $past(mv_host_addr[c*32 +: 32]) + 32'd4));

        assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_req[c] && !beat_ack[c]) |=>
                ($stable(mv_local_addr[c*32 +: 32]) && $stable(mv_host_addr[c*32 +: 32]) && beat_req[c]));

        assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_done[c] |-> !beat_req[c]);

        assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(beat_req[c]) |-> xfer_done[c]);

        assert_start_no_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(beat_req[c]) |-> !xfer_done[c]);
    end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat_req      (beat_req),
    .beat_ack      (beat_ack),
    .xfer_done     (xfer_done),
    .mv_local_addr (mv_local_addr),
    .mv_host_addr  (mv_host_addr)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
    localparam int NCH = 3;
    localparam int AW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    beat_req;
    logic [NCH-1:0]    beat_ack = '0;
    logic [NCH-1:0]    mv_dir;
    logic [NCH*32-1:0] mv_local_addr;
    logic [NCH*32-1:0] mv_host_addr;
    logic [NCH-1:0]    xfer_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_chan_regs #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_req(beat_req),
        .beat_ack(beat_ack), .mv_dir(mv_dir), .mv_local_addr(mv_local_addr),
        .mv_host_addr(mv_host_addr), .xfer_done(xfer_done)
    );

    // {addr, write data, expected readback}
    localparam logic [71:0] TBL [0:6] = '{
        {8'h00, 32'h1000_0000, 32'h1000_0000},
        {8'h04, 32'h8000_0040, 32'h8000_0040},
        {8'h08, 32'h1AC0_0010, 32'h1AC0_0010},
        {8'h18, 32'hE43F_FFFF, 32'h003F_FFFF},
        {8'h24, 32'hDEAD_BEEC, 32'hDEAD_BEEC},
        {8'h34, 32'h1234_5678, 32'h0000_0000},
        {8'h0C, 32'hCAFE_F00D, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[AW-1:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a[AW-1:0];
        #1;
        d = reg_rdata;
    endtask

    task automatic beat(input logic [NCH-1:0] m);
        @(negedge clk);
        beat_ack = m;
        @(negedge clk);
        beat_ack = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        rd(8'h08, v); check("R9 ctrl0 after reset", v, 32'h0);
        rd(8'h14, v); check("R9 host1 after reset", v, 32'h0);
        check("R9 beat_req after reset", 32'(beat_req), 32'h0);
        check("R9 xfer_done after reset", 32'(xfer_done), 32'h0);

        // R1 R2: table walk
        for (int i = 0; i < 7; i++) begin
            wr(TBL[i][71:64], TBL[i][63:32]);
            rd(TBL[i][71:64], v);
            check($sformatf("R1 R2 table entry %0d", i), v, TBL[i][31:0]);
        end
        rd(8'h00, v); check("R1 ch0 local untouched by other groups", v, 32'h1000_0000);

        // R3 R10: start ch0, count 3, dir 1, keep b27 b25
        wr(8'h00, 32'h0000_0100);
        wr(8'h04, 32'h0000_2000);
        wr(8'h08, 32'h1B00_0003);
        rd(8'h08, v); check("R3 ctrl busy readback", v, 32'h1B00_0003);
        check("R3 beat_req busy", 32'(beat_req), 32'h1);
        check("R10 mv_dir ch0", 32'(mv_dir[0]), 32'h1);
        check("R10 mv_local ch0", mv_local_addr[31:0], 32'h0000_0100);

        // R4: writes while busy ignored
        wr(8'h08, 32'h0100_0007);
        rd(8'h08, v); check("R4 restart ignored", v, 32'h1B00_0003);
        wr(8'h00, 32'h0000_FFF0);
        rd(8'h00, v); check("R4 local write ignored", v, 32'h0000_0100);

        // R5: beats with gaps
        beat(3'b001);
        rd(8'h08, v); check("R5 count after beat1", v, 32'h1B00_0002);
        check("R5 local after beat1", mv_local_addr[31:0], 32'h0000_0104);
        check("R5 host after beat1", mv_host_addr[31:0], 32'h0000_2004);
        repeat (2) @(negedge clk);
        rd(8'h04, v); check("R5 host stable without ack", v, 32'h0000_2004);
        beat(3'b001);
        check("R6 no done before last beat", 32'(xfer_done), 32'h0);
        beat(3'b001);
        check("R6 done pulse", 32'(xfer_done), 32'h1);
        check("R6 busy cleared", 32'(beat_req), 32'h0);
        rd(8'h08, v); check("R6 R2 ctrl after finish", v, 32'h1A00_0000);
        rd(8'h00, v); check("R6 final local", v, 32'h0000_010C);
        @(negedge clk);
        check("R6 done single cycle", 32'(xfer_done), 32'h0);

        // R7: zero-count start on ch1
        wr(8'h18, 32'h0100_0000);
        check("R7 zero start done", 32'(xfer_done), 32'h2);
        check("R7 zero start not busy", 32'(beat_req), 32'h0);
        @(negedge clk);
        check("R7 zero start done one cycle", 32'(xfer_done), 32'h0);

        // R8 R5: ch2 runs while ch0 idle gets acks
        wr(8'h20, 32'h0000_0040);
        wr(8'h24, 32'h0000_0080);
        wr(8'h28, 32'h0100_0002);
        check("R10 mv_dir ch2", 32'(mv_dir[2]), 32'h0);
        beat(3'b101);
        check("R5 idle ch0 ack ignored", mv_local_addr[31:0], 32'h0000_010C);
        check("R8 ch2 local advanced", mv_local_addr[95:64], 32'h0000_0044);
        rd(8'h18, v); check("R8 ch1 ctrl untouched", v, 32'h0000_0000);
        beat(3'b100);
        check("R6 ch2 done", 32'(xfer_done), 32'h4);
        check("R8 ch2 host final", mv_host_addr[95:64], 32'h0000_0088);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule